// File: doc/BRIEF.md
# Late-Write Buffer with Read Bypass

This block sits between a synchronous command port and a small single-port register array and gives the array late-write behaviour. A write command supplies its address on one rising edge. Its data arrives on the following edge and is parked in a pending-write register. That register is copied into the array only when the data of the next write is captured. Reads see the most recent write at all times: every read beat whose address matches the pending write takes its data from the pending register instead of the array.

Commands can be single-rate (one data beat per cycle) or double-rate (two beats per cycle, carried side by side on a port twice as wide). A load command starts a burst. Later CONTINUE commands step through a four-word group, in either linear or XOR order, and wrap inside it. A sequencer with three states drives the command flow:
- `ST_IDLE` moves to `ST_READ` on READ and to `ST_WRITE` on WRITE. It ignores CONTINUE and stays in `ST_IDLE` on NOP.
- `ST_READ` and `ST_WRITE` reload on READ or WRITE, advance the burst on CONTINUE, and return to `ST_IDLE` on NOP.

The protocol requires an idle cycle between a read and a write. A write that follows a read directly is executed and also flagged.

Top module: `late_write_buffer`

## Requirements
- R1: After reset `rvalid`, `proto_err` and `rdata` are 0, every array word reads as 0, and no pending write exists.
- R2: `cmd` encodes 00 NOP, 01 READ (load), 10 WRITE (load), 11 CONTINUE. On a load, `ddr` and `order_xor` are sampled and held for the rest of the burst.
- R3: Write data is sampled on the rising edge after the write command. Beat 0 is `wdata[DW-1:0]`. On a double-rate write, beat 1 is `wdata[2*DW-1:DW]`.
- R4: A read sampled at edge E sets `rvalid` and `rdata` at edge E+1. Beat 0 is in `rdata[DW-1:0]`. Beat 1 is in the upper half on a double-rate read, and the upper half is 0 on a single-rate read.
- R5: A read of an address held in the pending register returns the pending data, including a read issued in the cycle right after the write command.
- R6: The pending data reaches the array when a later write's data is captured. Every earlier write stays readable after any number of later writes.
- R7: Beat k of a burst uses the upper address bits of the start address. Its low two bits are start+k modulo 4 when `order_xor`=0, or start XOR k when `order_xor`=1. CONTINUE advances k by 1 for single rate and by 2 for double rate, and wraps after the fourth word.
- R8: CONTINUE in `ST_IDLE` has no effect: it produces no read data and no write.
- R9: A WRITE sampled on the edge right after an edge that performed a read sets `proto_err` high for exactly one cycle. The write is still carried out.
- R10: Each beat of a read is compared against both addresses of a double-rate pending write and takes the matching beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Command code (R2) |
| ddr | input | 1 | Double-rate select, sampled on a load |
| order_xor | input | 1 | Burst order, 1 selects XOR order, sampled on a load |
| addr | input | AW | Start address, sampled on a load |
| wdata | input | 2*DW | Write data, two beats |
| rdata | output | 2*DW | Read data, two beats |
| rvalid | output | 1 | Read data valid |
| proto_err | output | 1 | Read-to-write spacing violation |

## Verification
The assertions check on every cycle the properties that can be seen at the ports:
- the two-cycle spacing between a READ or NOP command and the matching `rvalid` level;
- the zero upper half of single-rate read data;
- that `proto_err` is a single-cycle pulse caused only by a WRITE.

Whether the data itself is correct can only be shown by the bench scenarios, because it depends on history. These scenarios cover bypass right after a write, data that has been committed past several later writes, double-rate pending hits on either beat, burst wrap in both orders, CONTINUE while idle, and a write that is flagged yet still lands.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_CONT  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    // low two address bits of burst beat k
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] k,
                                             input logic       xo);
        return xo ? (start ^ k) : (start + k);
    endfunction

endpackage

// File: rtl/lwb_seq.sv
module lwb_seq
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cmd_i,
    input  logic          ddr_i,
    input  logic          xo_i,
    input  logic [AW-1:0] addr_i,
    output logic          op_rd_o,
    output logic          op_wr_o,
    output logic          op_ddr_o,
    output logic [AW-1:0] op_a0_o,
    output logic [AW-1:0] op_a1_o,
    output logic          perr_o
);
    state_e        state_q, state_d;
    logic [AW-1:0] base_q;
    logic [1:0]    off_q;
    logic          ddr_q, xo_q, last_rd_q, perr_q;
    logic          load, cont;
    logic [AW-1:0] op_base;
    logic [1:0]    op_off;
    logic          op_xo;
    cmd_e          c;

    assign c = cmd_e'(cmd_i);

    // next state
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        cont    = 1'b0;
        unique case (c)
            CMD_NOP:   state_d = ST_IDLE;
            CMD_READ:  begin state_d = ST_READ;  load = 1'b1; end
            CMD_WRITE: begin state_d = ST_WRITE; load = 1'b1; end
            CMD_CONT:  cont = (state_q != ST_IDLE);
        endcase
    end

    // outputs
    always_comb begin
        op_base  = load ? addr_i : base_q;
        op_off   = load ? 2'd0 : off_q + (ddr_q ? 2'd2 : 2'd1);
        op_ddr_o = load ? ddr_i : ddr_q;
        op_xo    = load ? xo_i : xo_q;
        op_rd_o  = (load && c == CMD_READ)  || (cont && state_q == ST_READ);
        op_wr_o  = (load && c == CMD_WRITE) || (cont && state_q == ST_WRITE);
        op_a0_o  = {op_base[AW-1:2], burst_low(op_base[1:0], op_off, op_xo)};
        op_a1_o  = {op_base[AW-1:2], burst_low(op_base[1:0], op_off + 2'd1, op_xo)};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            base_q    <= '0;
            off_q     <= '0;
            ddr_q     <= 1'b0;
            xo_q      <= 1'b0;
            last_rd_q <= 1'b0;
            perr_q    <= 1'b0;
        end else begin
            state_q   <= state_d;
            if (load || cont) begin
                base_q <= op_base;
                off_q  <= op_off;
                ddr_q  <= op_ddr_o;
                xo_q   <= op_xo;
            end
            last_rd_q <= op_rd_o;
            perr_q    <= op_wr_o && last_rd_q;
        end
    end

    assign perr_o = perr_q;

endmodule

// File: rtl/lwb_pend.sv
module lwb_pend #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_wr_i,
    input  logic            op_ddr_i,
    input  logic [AW-1:0]   op_a0_i,
    input  logic [AW-1:0]   op_a1_i,
    input  logic [2*DW-1:0] wdata_i,
    output logic            cm_en_o,
    output logic            cm_ddr_o,
    output logic [AW-1:0]   cm_a0_o,
    output logic [AW-1:0]   cm_a1_o,
    output logic [DW-1:0]   cm_d0_o,
    output logic [DW-1:0]   cm_d1_o,
    input  logic [AW-1:0]   lk_a0_i,
    input  logic [AW-1:0]   lk_a1_i,
    output logic [1:0]      hit_o,
    output logic [2*DW-1:0] hdata_o
);
    localparam int NB = 2;

    logic          stg_v, stg_ddr;
    logic [AW-1:0] stg_a0, stg_a1;
    logic          pnd_v, pnd_ddr;
    logic [AW-1:0] pnd_a0, pnd_a1;
    logic [DW-1:0] pnd_d0, pnd_d1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v   <= 1'b0;
            stg_ddr <= 1'b0;
            stg_a0  <= '0;
            stg_a1  <= '0;
            pnd_v   <= 1'b0;
            pnd_ddr <= 1'b0;
            pnd_a0  <= '0;
            pnd_a1  <= '0;
            pnd_d0  <= '0;
            pnd_d1  <= '0;
        end else begin
            stg_v <= op_wr_i;
            if (op_wr_i) begin
                stg_ddr <= op_ddr_i;
                stg_a0  <= op_a0_i;
                stg_a1  <= op_a1_i;
            end
            if (stg_v) begin
                pnd_v   <= 1'b1;
                pnd_ddr <= stg_ddr;
                pnd_a0  <= stg_a0;
                pnd_a1  <= stg_a1;
                pnd_d0  <= wdata_i[DW-1:0];
                pnd_d1  <= wdata_i[2*DW-1:DW];
            end
        end
    end

    // old pending contents go to the array when new data lands
    assign cm_en_o  = stg_v && pnd_v;
    assign cm_ddr_o = pnd_ddr;
    assign cm_a0_o  = pnd_a0;
    assign cm_a1_o  = pnd_a1;
    assign cm_d0_o  = pnd_d0;
    assign cm_d1_o  = pnd_d1;

    for (genvar b = 0; b < NB; b++) begin : g_cmp
        logic [AW-1:0] la;
        logic          m0, m1;
        assign la = (b == 0) ? lk_a0_i : lk_a1_i;
        assign m0 = pnd_v && (la == pnd_a0);
        assign m1 = pnd_v && pnd_ddr && (la == pnd_a1);
        assign hit_o[b] = m0 || m1;
        assign hdata_o[b*DW +: DW] = m0 ? pnd_d0 : pnd_d1;
    end

endmodule

// File: rtl/lwb_array.sv
module lwb_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we0_i,
    input  logic          we1_i,
    input  logic [AW-1:0] wa0_i,
    input  logic [AW-1:0] wa1_i,
    input  logic [DW-1:0] wd0_i,
    input  logic [DW-1:0] wd1_i,
    input  logic [AW-1:0] ra0_i,
    input  logic [AW-1:0] ra1_i,
    output logic [DW-1:0] rd0_o,
    output logic [DW-1:0] rd1_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (we0_i) mem[wa0_i] <= wd0_i;
            if (we1_i) mem[wa1_i] <= wd1_i;
        end
    end

    assign rd0_o = mem[ra0_i];
    assign rd1_o = mem[ra1_i];

endmodule

// File: rtl/late_write_buffer.sv
module late_write_buffer #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cmd,
    input  logic            ddr,
    input  logic            order_xor,
    input  logic [AW-1:0]   addr,
    input  logic [2*DW-1:0] wdata,
    output logic [2*DW-1:0] rdata,
    output logic            rvalid,
    output logic            proto_err
);
    localparam int NB = 2;

    logic          op_rd, op_wr, op_ddr;
    logic [AW-1:0] op_a0, op_a1;
    logic          cm_en, cm_ddr;
    logic [AW-1:0] cm_a0, cm_a1;
    logic [DW-1:0] cm_d0, cm_d1;
    logic          rq_v, rq_ddr;
    logic [AW-1:0] rq_a0, rq_a1;
    logic [1:0]    hit;
    logic [2*DW-1:0] hdata, adata, beat;

    lwb_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .ddr_i(ddr), .xo_i(order_xor),
        .addr_i(addr), .op_rd_o(op_rd), .op_wr_o(op_wr), .op_ddr_o(op_ddr),
        .op_a0_o(op_a0), .op_a1_o(op_a1), .perr_o(proto_err)
    );

    lwb_pend #(.AW(AW), .DW(DW)) u_pend (
        .clk(clk), .rst_n(rst_n), .op_wr_i(op_wr), .op_ddr_i(op_ddr),
        .op_a0_i(op_a0), .op_a1_i(op_a1), .wdata_i(wdata),
        .cm_en_o(cm_en), .cm_ddr_o(cm_ddr), .cm_a0_o(cm_a0), .cm_a1_o(cm_a1),
        .cm_d0_o(cm_d0), .cm_d1_o(cm_d1), .lk_a0_i(rq_a0), .lk_a1_i(rq_a1),
        .hit_o(hit), .hdata_o(hdata)
    );

    lwb_array #(.AW(AW), .DW(DW)) u_arr (
        .clk(clk), .rst_n(rst_n), .we0_i(cm_en), .we1_i(cm_en && cm_ddr),
        .wa0_i(cm_a0), .wa1_i(cm_a1), .wd0_i(cm_d0), .wd1_i(cm_d1),
        .ra0_i(rq_a0), .ra1_i(rq_a1),
        .rd0_o(adata[DW-1:0]), .rd1_o(adata[2*DW-1:DW])
    );

    for (genvar b = 0; b < NB; b++) begin : g_sel
        assign beat[b*DW +: DW] = hit[b] ? hdata[b*DW +: DW] : adata[b*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_v   <= 1'b0;
            rq_ddr <= 1'b0;
            rq_a0  <= '0;
            rq_a1  <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rq_v <= op_rd;
            if (op_rd) begin
                rq_ddr <= op_ddr;
                rq_a0  <= op_a0;
                rq_a1  <= op_a1;
            end
            rvalid <= rq_v;
            if (rq_v) rdata <= {rq_ddr ? beat[2*DW-1:DW] : {DW{1'b0}}, beat[DW-1:0]};
        end
    end

endmodule

// File: rtl/lwb_chk.sv
module lwb_chk #(
    parameter int DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cmd,
    input logic            ddr,
    input logic [2*DW-1:0] rdata,
    input logic            rvalid,
    input logic            proto_err
);
    // R9
    perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(cmd) == 2'b10);

    // R9
    perr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err);

    // R4
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b01 |-> ##2 rvalid);

    // R2
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == 2'b00 |-> ##2 !rvalid);

    // R4
    sdr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'b01 && !ddr) |-> ##2 (rdata[2*DW-1:DW] == '0));

endmodule

bind late_write_buffer lwb_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .ddr(ddr),
    .rdata(rdata), .rvalid(rvalid), .proto_err(proto_err)
);

// File: tb/late_write_buffer_test.sv
module late_write_buffer_test;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, CT = 2'b11;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      cmd = NOP;
    logic            ddr = 1'b0, order_xor = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [2*DW-1:0] wdata = '0;
    logic [2*DW-1:0] rdata;
    logic            rvalid, proto_err;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    logic [DW-1:0]   model [1<<AW];
    logic [2*DW-1:0] q_data [$];
    int              q_due  [$];
    string           q_tag  [$];

    // bench-side burst tracking
    logic [AW-1:0] b_base;
    logic [1:0]    b_off;
    logic          b_ddr, b_xo, last_rd;
    int            b_mode;
    logic          pw_v, pw_ddr;
    logic [AW-1:0] pw_a0, pw_a1;

    late_write_buffer #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ddr(ddr), .order_xor(order_xor),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .proto_err(proto_err)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [1:0] low_bits(input logic [1:0] s, input logic [1:0] k, input logic x);
        return x ? (s ^ k) : (s + k);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare read results against queued expectations
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            if (q_data.size() == 0) check(0, "R8 unexpected rvalid", rdata, '0);
            else begin
                logic [2*DW-1:0] e;
                int d;
                string t;
                e = q_data.pop_front(); d = q_due.pop_front(); t = q_tag.pop_front();
                check(rdata == e && d == cyc, t, rdata, e);
            end
        end
    end

    // driver: one command per cycle; wd carries data of the previous write op
    task automatic step(input logic [1:0] c, input logic [AW-1:0] a, input logic d,
                        input logic x, input logic [2*DW-1:0] wd, input string tag);
        bit is_op, rd_now, exp_pe;
        logic [AW-1:0] a0, a1;
        if (pw_v) begin
            model[pw_a0] = wd[DW-1:0];
            if (pw_ddr) model[pw_a1] = wd[2*DW-1:DW];
            pw_v = 0;
        end
        is_op = 0; rd_now = 0;
        if (c == RD || c == WR) begin
            b_base = a; b_off = 0; b_ddr = d; b_xo = x; b_mode = (c == RD) ? 1 : 2; is_op = 1;
        end else if (c == CT && b_mode != 0) begin
            b_off = b_off + (b_ddr ? 2'd2 : 2'd1); is_op = 1;
        end else if (c == NOP) b_mode = 0;
        a0 = {b_base[AW-1:2], low_bits(b_base[1:0], b_off, b_xo)};
        a1 = {b_base[AW-1:2], low_bits(b_base[1:0], b_off + 2'd1, b_xo)};
        if (is_op && b_mode == 1) begin
            q_data.push_back({b_ddr ? model[a1] : {DW{1'b0}}, model[a0]});
            q_due.push_back(cyc + 2);
            q_tag.push_back(tag);
            rd_now = 1;
        end
        if (is_op && b_mode == 2) begin
            pw_v = 1; pw_ddr = b_ddr; pw_a0 = a0; pw_a1 = a1;
        end
        exp_pe = (c == WR) && last_rd;
        last_rd = rd_now;
        cmd = c; addr = a; ddr = d; order_xor = x; wdata = wd;
        @(posedge clk);
        @(negedge clk);
        check(proto_err == exp_pe, "R9 proto_err", {31'b0, proto_err}, {31'b0, exp_pe});
    endtask

    initial begin
        #(8 * 5000);
        check(0, "watchdog", '0, '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1<<AW); i++) model[i] = '0;
        b_base = '0; b_off = '0; b_ddr = 0; b_xo = 0; b_mode = 0; last_rd = 0;
        pw_v = 0; pw_ddr = 0; pw_a0 = '0; pw_a1 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        check(rvalid == 0 && proto_err == 0 && rdata == '0, "R1 reset outputs", rdata, '0);
        step(RD, 6'd5, 0, 0, '0, "R1 array zero after reset");
        step(NOP, 0, 0, 0, '0, "R2");
        // R3/R5: write then immediate read bypass
        step(WR, 6'd3, 0, 0, '0, "R3");
        step(RD, 6'd3, 0, 0, 32'h0000_a1a1, "R5 bypass next cycle");
        step(NOP, 0, 0, 0, '0, "R2");
        // R6: commit chain
        step(WR, 6'd10, 0, 0, '0, "R6");
        step(WR, 6'd20, 0, 0, 32'h0000_1010, "R6");
        step(WR, 6'd30, 0, 0, 32'h0000_2020, "R6");
        step(NOP, 0, 0, 0, 32'h0000_3030, "R6");
        step(RD, 6'd10, 0, 0, '0, "R6 committed word 10");
        step(RD, 6'd20, 0, 0, '0, "R6 committed word 20");
        step(RD, 6'd3, 0, 0, '0, "R6 committed word 3");
        step(RD, 6'd30, 0, 0, '0, "R5 pending word 30");
        step(NOP, 0, 0, 0, '0, "R2");
        // R10: double-rate pending, read each beat
        step(WR, 6'd8, 1, 0, '0, "R3");
        step(RD, 6'd8, 1, 0, 32'hbbbb_aaaa, "R10 ddr pending both beats");
        step(RD, 6'd9, 0, 0, '0, "R10 second pending beat");
        step(RD, 6'd9, 1, 1, '0, "R10 xor order ddr read");
        step(NOP, 0, 0, 0, '0, "R2");
        // R7: linear SDR burst with wrap
        step(WR, 6'd13, 1, 0, '0, "R7");
        step(CT, 0, 0, 0, 32'h0e0e_0d0d, "R7");
        step(NOP, 0, 0, 0, 32'h0c0c_0f0f, "R7");
        step(RD, 6'd13, 0, 0, '0, "R7 linear beat0");
        step(CT, 0, 0, 0, '0, "R7 linear beat1");
        step(CT, 0, 0, 0, '0, "R7 linear beat2");
        step(CT, 0, 0, 0, '0, "R7 linear beat3 wrap");
        step(CT, 0, 0, 0, '0, "R7 linear wrap to start");
        step(RD, 6'd14, 1, 1, '0, "R7 xor ddr beat0");
        step(CT, 0, 0, 0, '0, "R7 xor ddr beat2");
        step(NOP, 0, 0, 0, '0, "R2");
        // R8: continue while idle does nothing
        step(CT, 6'd3, 1, 0, 32'hdead_beef, "R8");
        step(CT, 6'd3, 0, 0, 32'hdead_beef, "R8");
        step(NOP, 0, 0, 0, '0, "R8");
        step(RD, 6'd3, 0, 0, '0, "R8 word untouched");
        // R9: read then write directly
        step(WR, 6'd40, 0, 0, '0, "R9");
        step(NOP, 0, 0, 0, 32'h0000_4444, "R9");
        step(RD, 6'd40, 0, 0, '0, "R9 flagged write landed");
        step(NOP, 0, 0, 0, '0, "R2");
        step(WR, 6'd41, 0, 0, '0, "R6");
        step(NOP, 0, 0, 0, 32'h0000_5555, "R6");
        step(RD, 6'd40, 0, 0, '0, "R6 flagged write committed");
        repeat (4) step(NOP, 0, 0, 0, '0, "R2");
        check(q_data.size() == 0, "R4 all reads returned", q_data.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule